// File: doc/BRIEF.md
# CAN Edge Synchronization Decision Unit

This block sits beside a CAN bit timing unit and decides, for every bus edge, whether the timer must be realigned. It watches a bus input that has already been synchronized to the clock. It keeps the level captured at the last sample point and counts time quanta from that sample point. From these it classifies each edge in one of three ways: it starts a hard synchronization, it becomes a resynchronization with a signed phase correction, or it is ignored.

The bit timer consumes two outputs. A one-cycle hard-sync pulse tells the timer to restart its bit at the end of the sync segment. A one-cycle resync pulse carries a signed correction in quanta. A positive correction lengthens phase segment 1. A negative correction shortens phase segment 2. The timer supplies the quantum tick, the sample-point strobe, the length of phase segment 2, the jump-width setting, and the bus-idle and transmitting flags.

Top module: `can_sync_ctrl`

## Requirements
- R1: At most one synchronization pulse (hard or resync) is issued between two consecutive sample points. A further qualified edge inside the same window produces no pulse until a sample point has passed.
- R2: An edge is used only if the level captured at the last sample point differs from the bus level just after the edge. Otherwise neither pulse is issued.
- R3: A falling edge (recessive 1 to dominant 0) that qualifies while `bus_idle_i` is 1 gives `hsync_o` = 1 one cycle after the edge, with `rsync_o` = 0 and `phase_adj_o` = 0.
- R4: While `bus_idle_i` is 0, qualified falling edges are resynchronization candidates. Rising edges (0 to 1) are candidates only when `both_edges_i` is 1. A rising edge never causes a hard sync.
- R5: When `both_edges_i` is 0 and `tx_active_i` is 1, a falling edge with a positive phase error produces no pulse. A falling edge with a zero or negative error still resynchronizes. With `both_edges_i` = 1 no edge is suppressed this way.
- R6: The phase error equals c − `tseg2_i`, where c is the number of quantum ticks since the last sample point (the counter restarts to 0 at a sample point). An edge while c equals `tseg2_i` lies in the sync segment and gives error 0. Ticks advance c only when `tq_tick_i` is 1, and a sample strobe is only given together with a tick.
- R7: The correction on `phase_adj_o` (two's complement) is the phase error clamped to ±(`sjw_cfg_i` + 1). It appears with `rsync_o` = 1 one cycle after the edge.
- R8: A hard synchronization closes the window: no resync and no second hard sync follow until the next sample point. The internal quantum count restarts just past the sync segment.
- R9: After reset both pulses are 0 and `phase_adj_o` is 0. The stored sample level and the previous bus level are both recessive (1), so a first falling edge qualifies.
- R10: `phase_adj_o` is 0 in every cycle in which `rsync_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_i | input | 1 | Synchronized bus level, 0 dominant, 1 recessive |
| tq_tick_i | input | 1 | Time quantum tick |
| sample_pt_i | input | 1 | Sample-point strobe, given with a tick |
| bus_idle_i | input | 1 | Bus is idle |
| tx_active_i | input | 1 | Node is transmitting |
| both_edges_i | input | 1 | 1: rising edges also resynchronize |
| sjw_cfg_i | input | SJW_W | Jump width minus one |
| tseg2_i | input | SEG_W | Phase segment 2 length in quanta |
| hsync_o | output | 1 | Hard synchronization pulse |
| rsync_o | output | 1 | Resynchronization pulse |
| phase_adj_o | output | SJW_W+2 | Signed correction in quanta |

## Verification
The assertions assume a sample strobe never appears without a quantum tick. They also assume `sjw_cfg_i`, `tseg2_i` and `both_edges_i` stay constant from an edge until its pulse has been seen. The bench changes configuration only at negative edges after the outcome of an edge has been checked, so every change falls in a quiet stretch of the bus. The stimulus raises the strobe only while the tick is held high. It sweeps segment length, jump width and edge position, and covers each mode in turn: transmitting, both-edge and idle.

// File: rtl/can_sync_pkg.sv
package can_sync_pkg;

    localparam logic DOMINANT  = 1'b0;
    localparam logic RECESSIVE = 1'b1;

    typedef enum logic [1:0] {
        SYNC_NONE   = 2'd0,
        SYNC_HARD   = 2'd1,
        SYNC_RESYNC = 2'd2
    } sync_kind_e;

endpackage

// File: rtl/can_sync_edge.sv
module can_sync_edge
    import can_sync_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic rx_i,
    input  logic sample_i,
    output logic fall_o,
    output logic rise_o,
    output logic differs_o
);

    typedef struct packed {
        logic rx_prev;
        logic sampled;
    } edge_st_t;

    edge_st_t st_q, st_d;

    always_comb begin
        st_d         = st_q;
        st_d.rx_prev = rx_i;
        if (sample_i) begin
            st_d.sampled = rx_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{rx_prev: RECESSIVE, sampled: RECESSIVE};
        end else begin
            st_q <= st_d;
        end
    end

    assign fall_o    = (st_q.rx_prev == RECESSIVE) && (rx_i == DOMINANT);
    assign rise_o    = (st_q.rx_prev == DOMINANT)  && (rx_i == RECESSIVE);
    assign differs_o = (st_q.sampled != rx_i);

endmodule

// File: rtl/can_sync_phase.sv
module can_sync_phase #(
    parameter int CNT_W = 5,
    parameter int SEG_W = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    tq_tick_i,
    input  logic                    sample_i,
    input  logic                    hard_i,
    input  logic [SEG_W-1:0]        tseg2_i,
    output logic signed [CNT_W:0]   perr_o
);

    localparam logic [CNT_W-1:0] CNT_MAX = '1;
    localparam int               PAD_W   = CNT_W + 1 - SEG_W;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } ph_st_t;

    ph_st_t st_q, st_d;

    always_comb begin
        st_d = st_q;
        if (hard_i) begin
            st_d.cnt = CNT_W'(tseg2_i) + CNT_W'(1);
        end else if (sample_i) begin
            st_d.cnt = '0;
        end else if (tq_tick_i && (st_q.cnt != CNT_MAX)) begin
            st_d.cnt = st_q.cnt + CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign perr_o = $signed({1'b0, st_q.cnt}) - $signed({{PAD_W{1'b0}}, tseg2_i});

    AST_HARD_PAST_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
        hard_i |=> (perr_o > 0)); // R8

endmodule

// File: rtl/can_sync_decide.sv
module can_sync_decide
    import can_sync_pkg::*;
#(
    parameter int SJW_W = 2,
    parameter int ERR_W = 6,
    parameter int ADJ_W = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    fall_i,
    input  logic                    rise_i,
    input  logic                    differs_i,
    input  logic                    sample_i,
    input  logic                    bus_idle_i,
    input  logic                    tx_active_i,
    input  logic                    both_edges_i,
    input  logic [SJW_W-1:0]        sjw_cfg_i,
    input  logic signed [ERR_W-1:0] perr_i,
    output logic                    hard_o,
    output logic                    hsync_o,
    output logic                    rsync_o,
    output logic signed [ADJ_W-1:0] phase_adj_o
);

    typedef struct packed {
        logic                    done;
        logic                    hsync;
        logic                    rsync;
        logic signed [ADJ_W-1:0] adj;
    } dec_st_t;

    dec_st_t                 st_q, st_d;
    sync_kind_e              kind;
    logic signed [ERR_W-1:0] lim;
    logic signed [ERR_W-1:0] clamped;
    logic                    candidate;
    logic                    suppress;

    always_comb begin
        lim = ERR_W'(sjw_cfg_i) + ERR_W'(1);
        if (perr_i > lim) begin
            clamped = lim;
        end else if (perr_i < -lim) begin
            clamped = -lim;
        end else begin
            clamped = perr_i;
        end
    end

    always_comb begin
        kind      = SYNC_NONE;
        candidate = fall_i || (rise_i && both_edges_i);
        suppress  = tx_active_i && !both_edges_i && fall_i && (perr_i > 0);
        if (!st_q.done && differs_i) begin
            if (bus_idle_i) begin
                if (fall_i) begin
                    kind = SYNC_HARD;
                end
            end else if (candidate && !suppress) begin
                kind = SYNC_RESYNC;
            end
        end
    end

    always_comb begin
        st_d       = st_q;
        st_d.done  = sample_i ? 1'b0 : st_q.done;
        if (kind != SYNC_NONE) begin
            st_d.done = 1'b1;
        end
        st_d.hsync = (kind == SYNC_HARD);
        st_d.rsync = (kind == SYNC_RESYNC);
        st_d.adj   = (kind == SYNC_RESYNC) ? ADJ_W'(clamped) : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign hard_o      = (kind == SYNC_HARD);
    assign hsync_o     = st_q.hsync;
    assign rsync_o     = st_q.rsync;
    assign phase_adj_o = st_q.adj;

    AST_ONE_SYNC_PER_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        (hsync_o || rsync_o) |=> !(hsync_o || rsync_o)); // R1
    AST_SYNC_QUALIFIED: assert property (@(posedge clk) disable iff (!rst_n)
        (hsync_o || rsync_o) |-> $past(differs_i)); // R2
    AST_HARD_ONLY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        hsync_o |-> ($past(bus_idle_i) && $past(fall_i))); // R3
    AST_RESYNC_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        rsync_o |-> !$past(bus_idle_i)); // R4
    AST_TX_NO_LENGTHEN: assert property (@(posedge clk) disable iff (!rst_n)
        (rsync_o && $past(tx_active_i && !both_edges_i)) |-> (phase_adj_o <= 0)); // R5
    AST_ADJ_WITHIN_SJW: assert property (@(posedge clk) disable iff (!rst_n)
        rsync_o |-> ((phase_adj_o <= lim) && (phase_adj_o >= -lim))); // R7
    AST_ADJ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !rsync_o |-> (phase_adj_o == 0)); // R10

endmodule

// File: rtl/can_sync_ctrl.sv
module can_sync_ctrl
    import can_sync_pkg::*;
#(
    parameter int SJW_W = 2,
    parameter int SEG_W = 4,
    parameter int CNT_W = 5,
    localparam int ERR_W = CNT_W + 1,
    localparam int ADJ_W = SJW_W + 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    rx_i,
    input  logic                    tq_tick_i,
    input  logic                    sample_pt_i,
    input  logic                    bus_idle_i,
    input  logic                    tx_active_i,
    input  logic                    both_edges_i,
    input  logic [SJW_W-1:0]        sjw_cfg_i,
    input  logic [SEG_W-1:0]        tseg2_i,
    output logic                    hsync_o,
    output logic                    rsync_o,
    output logic signed [ADJ_W-1:0] phase_adj_o
);

    logic                    sample_s;
    logic                    fall_s;
    logic                    rise_s;
    logic                    differs_s;
    logic                    hard_s;
    logic signed [ERR_W-1:0] perr_s;

    assign sample_s = tq_tick_i && sample_pt_i;

    can_sync_edge u_edge (
        .clk       (clk),
        .rst_n     (rst_n),
        .rx_i      (rx_i),
        .sample_i  (sample_s),
        .fall_o    (fall_s),
        .rise_o    (rise_s),
        .differs_o (differs_s)
    );

    can_sync_phase #(
        .CNT_W (CNT_W),
        .SEG_W (SEG_W)
    ) u_phase (
        .clk       (clk),
        .rst_n     (rst_n),
        .tq_tick_i (tq_tick_i),
        .sample_i  (sample_s),
        .hard_i    (hard_s),
        .tseg2_i   (tseg2_i),
        .perr_o    (perr_s)
    );

    can_sync_decide #(
        .SJW_W (SJW_W),
        .ERR_W (ERR_W),
        .ADJ_W (ADJ_W)
    ) u_decide (
        .clk          (clk),
        .rst_n        (rst_n),
        .fall_i       (fall_s),
        .rise_i       (rise_s),
        .differs_i    (differs_s),
        .sample_i     (sample_s),
        .bus_idle_i   (bus_idle_i),
        .tx_active_i  (tx_active_i),
        .both_edges_i (both_edges_i),
        .sjw_cfg_i    (sjw_cfg_i),
        .perr_i       (perr_s),
        .hard_o       (hard_s),
        .hsync_o      (hsync_o),
        .rsync_o      (rsync_o),
        .phase_adj_o  (phase_adj_o)
    );

    AST_SAMPLE_WITH_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        sample_pt_i |-> tq_tick_i); // R6

endmodule

// File: tb/sim_can_sync_ctrl.sv
`timescale 1ns/1ps
module sim_can_sync_ctrl;

    logic              clk = 1'b0;
    logic              rst_n;
    logic              rx, tick, spt, idle, tx, both;
    logic [1:0]        sjw;
    logic [3:0]        tseg2;
    logic              hsync, rsync;
    logic signed [3:0] adj;
    int                n_chk = 0;
    int                n_bad = 0;
    logic              finished = 1'b0;

    always #2.5 clk = ~clk;

    can_sync_ctrl u0 (
        .clk          (clk),
        .rst_n        (rst_n),
        .rx_i         (rx),
        .tq_tick_i    (tick),
        .sample_pt_i  (spt),
        .bus_idle_i   (idle),
        .tx_active_i  (tx),
        .both_edges_i (both),
        .sjw_cfg_i    (sjw),
        .tseg2_i      (tseg2),
        .hsync_o      (hsync),
        .rsync_o      (rsync),
        .phase_adj_o  (adj)
    );

    function automatic int exp_adj(input int k, input int t, input int s);
        int e;
        int l;
        e = k - t;
        l = s + 1;
        if (e > l)  e = l;
        if (e < -l) e = -l;
        return e;
    endfunction

    task automatic chk(input string tag, input logic eh, input logic er, input int ea);
        n_chk++;
        if (hsync !== eh || rsync !== er || int'(adj) !== ea) begin
            n_bad++;
            $display("FAIL %s: actual h=%0b r=%0b adj=%0d expected h=%0b r=%0b adj=%0d",
                     tag, hsync, rsync, int'(adj), eh, er, ea);
        end
    endtask

    task automatic mark_sample(input logic v);
        rx   = v;
        tick = 1'b1;
        spt  = 1'b1;
        @(negedge clk);
        spt  = 1'b0;
    endtask

    task automatic step(input logic v);
        rx = v;
        @(negedge clk);
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; rx = 1'b1; tick = 1'b1; spt = 1'b0; idle = 1'b0;
        tx = 1'b0; both = 1'b0; sjw = 2'd0; tseg2 = 4'd3;
        repeat (3) @(negedge clk);
        chk("R9 reset outputs", 1'b0, 1'b0, 0);
        rst_n = 1'b1;
        @(negedge clk);
        // R9: stored sample is recessive after reset, so this fall qualifies (count 1)
        step(1'b0);
        chk("R9 first edge", 1'b0, 1'b1, exp_adj(1, 3, 0));
        step(1'b1);

        // R6 R7: sweep segment length, jump width and edge position
        for (int t = 1; t <= 6; t++) begin
            for (int s = 0; s <= 3; s++) begin
                for (int k = 0; k <= t + 5; k++) begin
                    tseg2 = 4'(t);
                    sjw   = 2'(s);
                    mark_sample(1'b1);
                    repeat (k) @(negedge clk);
                    step(1'b0);
                    chk($sformatf("R6 R7 t=%0d s=%0d k=%0d", t, s, k), 1'b0, 1'b1, exp_adj(k, t, s));
                    step(1'b1);
                end
            end
        end

        // R5: transmitting with falling edges only, then with both edges
        tseg2 = 4'd3; sjw = 2'd3; tx = 1'b1;
        for (int b = 0; b <= 1; b++) begin
            both = logic'(b);
            for (int k = 0; k <= 8; k++) begin
                mark_sample(1'b1);
                repeat (k) @(negedge clk);
                step(1'b0);
                if (b == 0 && k > 3)
                    chk($sformatf("R5 suppressed k=%0d", k), 1'b0, 1'b0, 0);
                else
                    chk($sformatf("R5 allowed b=%0d k=%0d", b, k), 1'b0, 1'b1, exp_adj(k, 3, 3));
                step(1'b1);
            end
        end
        tx = 1'b0;

        // R4: rising edges, honoured only in both-edge mode
        tseg2 = 4'd4; sjw = 2'd1;
        for (int b = 0; b <= 1; b++) begin
            both = logic'(b);
            for (int k = 0; k <= 8; k++) begin
                step(1'b0);
                mark_sample(1'b0);
                repeat (k) @(negedge clk);
                step(1'b1);
                if (b == 1)
                    chk($sformatf("R4 rise k=%0d", k), 1'b0, 1'b1, exp_adj(k, 4, 1));
                else
                    chk($sformatf("R4 rise ignored k=%0d", k), 1'b0, 1'b0, 0);
            end
        end
        both = 1'b0;

        // R2: fall with sampled level already dominant is unqualified
        step(1'b0);
        mark_sample(1'b0);
        step(1'b1);
        chk("R2 rise ignored", 1'b0, 1'b0, 0);
        step(1'b0);
        chk("R2 unqualified fall", 1'b0, 1'b0, 0);
        step(1'b1);

        // R1: only one resync between sample points
        tseg2 = 4'd3; sjw = 2'd3;
        mark_sample(1'b1);
        repeat (2) @(negedge clk);
        step(1'b0);
        chk("R1 first resync", 1'b0, 1'b1, exp_adj(2, 3, 3));
        step(1'b1);
        step(1'b0);
        chk("R1 second edge blocked", 1'b0, 1'b0, 0);
        step(1'b1);
        mark_sample(1'b1);
        step(1'b0);
        chk("R1 window reopened", 1'b0, 1'b1, exp_adj(0, 3, 3));
        step(1'b1);

        // R3 R8: hard sync while idle, then window closed
        idle = 1'b1;
        mark_sample(1'b1);
        repeat (2) @(negedge clk);
        step(1'b0);
        chk("R3 hard sync", 1'b1, 1'b0, 0);
        step(1'b1);
        step(1'b0);
        chk("R8 second hard sync blocked", 1'b0, 1'b0, 0);
        idle = 1'b0;
        step(1'b1);
        step(1'b0);
        chk("R8 resync blocked after hard sync", 1'b0, 1'b0, 0);
        step(1'b1);

        // R2 R4 in idle: unqualified fall, and rising edge never hard-syncs
        idle = 1'b1;
        step(1'b0);
        mark_sample(1'b0);
        both = 1'b1;
        step(1'b1);
        chk("R4 idle rise ignored", 1'b0, 1'b0, 0);
        step(1'b0);
        chk("R2 idle unqualified fall", 1'b0, 1'b0, 0);
        both = 1'b0;
        mark_sample(1'b0);
        step(1'b1);
        mark_sample(1'b1);
        step(1'b0);
        chk("R3 idle fall after new sample", 1'b1, 1'b0, 0);
        step(1'b1);
        idle = 1'b0;

        // R6: count frozen without ticks
        tseg2 = 4'd5; sjw = 2'd3;
        mark_sample(1'b1);
        tick = 1'b0;
        repeat (6) @(negedge clk);
        step(1'b0);
        chk("R6 no ticks", 1'b0, 1'b1, exp_adj(0, 5, 3));
        tick = 1'b1;
        step(1'b1);

        // R6: ticks on alternate cycles, three ticks before the edge
        tseg2 = 4'd2; sjw = 2'd3;
        mark_sample(1'b1);
        for (int i = 0; i < 6; i++) begin
            tick = logic'(i % 2);
            @(negedge clk);
        end
        tick = 1'b1;
        step(1'b0);
        chk("R6 alternate ticks", 1'b0, 1'b1, exp_adj(3, 2, 3));
        step(1'b1);

        finished = 1'b1;
        summary();
        $finish;
    end

endmodule